// File: doc/BRIEF.md
# Multi-Width Barrel Shifter and Bit-Field Unit

This unit performs the shift and bit-manipulation work of a signal-processing datapath. It shifts or rotates an operand by any distance within one cycle. The operand may be 16, 32 or 40 bits wide, and the 40-bit width covers an extended-precision accumulator. On a 32-bit value it also sets, clears, toggles or tests a single bit, and it extracts or deposits a contiguous field of bits.

Each operation is presented with a one-cycle `in_valid` strobe. The result is captured in an output register on the same clock edge, so it is visible one cycle after the strobe, and it holds until the next accepted operation. A separate one-bit flag reports the outcome of a bit test. The logic that decodes instructions and the register file that supplies operands sit outside this unit.

Top module: `bshift_bitfield`

## Requirements
- R1: While `rst_n` is low, `result` is 0 and `tflag` is 0.
- R2: `result` and `tflag` change only on the clock edge where `in_valid` is high. With `in_valid` low they hold their values whatever the other inputs do.
- R3: The `wsel` code selects the operand width: 0 is 16 bits, 1 is 32 bits, and 2 or 3 is 40 bits. For shift and rotate codes (0, 1, 2), source bits above the width are ignored and `result` bits above the width are 0.
- R4: Op code 0 is an arithmetic shift by the signed 7-bit `amt`. A positive amount shifts left with zero fill. A negative amount shifts right and copies the sign bit of the selected width. If the magnitude is at least the width, the result is 0 for a left shift and a copy of the sign bit in every position for a right shift.
- R5: Op code 1 is a logical shift. Positive `amt` shifts left and negative `amt` shifts right, with zero fill in both directions. A magnitude of at least the width gives 0.
- R6: Op code 2 rotates within the selected width. Positive `amt` rotates left and negative `amt` rotates right, and the distance is taken modulo the width.
- R7: Op codes 3, 4 and 5 set, clear and toggle bit `amt[4:0]` of `src[31:0]`. The other bits are copied, and `result[39:32]` is 0.
- R8: Op code 6 loads `tflag` with bit `amt[4:0]` of `src[31:0]` and leaves `result` unchanged. No other op code changes `tflag`.
- R9: Op code 7 extracts `flen` bits of `src[31:0]`, starting at bit `amt[4:0]`, and right-justifies them with zero fill. Field bits above bit 31 read as 0. A length of 0 gives 0, and a length of 32 or more keeps every bit from the start position upward.
- R10: Op code 8 extracts the field in the same way as R9 and then copies the field's top bit into every 32-bit position above the field. A length of 0 gives 0.
- R11: Op code 9 deposits `ins[flen-1:0]` into `src[31:0]`, starting at bit `amt[4:0]`. Field bits that would land above bit 31 are dropped, and every bit outside the field keeps its `src` value.
- R12: Op codes 10 to 15 leave `result` and `tflag` unchanged even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| wsel | input | 2 | Operand width select for shifts and rotates |
| src | input | 40 | Source operand |
| amt | input | 7 | Signed shift amount, or bit/field start position in bits 4:0 |
| flen | input | 6 | Field length for extract and deposit |
| ins | input | 32 | Value whose low bits are deposited |
| result | output | 40 | Registered result |
| tflag | output | 1 | Registered bit-test flag |

## Verification
Shifts and rotates are tried with single-bit and sign-bit patterns at each width, using positive and negative amounts as well as amounts beyond the width. These cases separate arithmetic fill from logical fill, show whether the width is masked, and show whether the rotate distance is reduced modulo a width that is not a power of two. Bit operations use the lowest and highest positions and an `amt` with high bits set. Field operations use windows that run past bit 31, zero-length fields, full-length fields, and negative and positive sign-extended fields. Together these cases expose errors in the masks and in the sign bit. Undefined codes, a bit test, and cycles without a strobe are each followed by a check that the registered result has not moved.

// File: rtl/bshift_bitfield.sv
module bshift_bitfield (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  op,
  input  logic [1:0]  wsel,
  input  logic [39:0] src,
  input  logic [6:0]  amt,
  input  logic [5:0]  flen,
  input  logic [31:0] ins,
  output logic [39:0] result,
  output logic        tflag
);
  localparam int DW = 40;
  localparam int BW = 32;

  logic [6:0]    wbits, mag, rmod, rl;
  logic [DW-1:0] wmask, zx, sx, shl, asr, lsr, rot;
  logic          sgn, neg;

  assign wbits = (wsel == 2'd0) ? 7'd16 : (wsel == 2'd1) ? 7'd32 : 7'd40;
  assign wmask = (wsel == 2'd0) ? 40'h00_0000_FFFF :
                 (wsel == 2'd1) ? 40'h00_FFFF_FFFF : {DW{1'b1}};
  assign sgn   = (wsel == 2'd0) ? src[15] : (wsel == 2'd1) ? src[31] : src[39];
  assign zx    = src & wmask;
  assign sx    = zx | (sgn ? ~wmask : '0);
  assign neg   = amt[6];
  assign mag   = neg ? (7'd0 - amt) : amt;

  assign shl = (zx << mag) & wmask;
  assign asr = DW'($signed(sx) >>> mag) & wmask;
  assign lsr = zx >> mag;

  always_comb begin
    case (wsel)
      2'd0:    rmod = {3'd0, mag[3:0]};
      2'd1:    rmod = {2'd0, mag[4:0]};
      default: rmod = (mag >= 7'd40) ? mag - 7'd40 : mag;
    endcase
    rl = (neg && rmod != 7'd0) ? wbits - rmod : rmod;
  end
  assign rot = ((zx << rl) | (zx >> (wbits - rl))) & wmask;

  logic [4:0]    pos, sidx;
  logic [BW-1:0] d32, bit1, lmask, ext, exts, dmask, dep;
  logic [BW:0]   lm33;
  logic          sbit;

  assign pos   = amt[4:0];
  assign d32   = src[BW-1:0];
  assign bit1  = {{(BW-1){1'b0}}, 1'b1} << pos;
  assign lm33  = ({{BW{1'b0}}, 1'b1} << flen) - {{BW{1'b0}}, 1'b1};
  assign lmask = lm33[BW-1:0];
  assign ext   = (d32 >> pos) & lmask;
  assign sidx  = (flen >= 6'd32) ? 5'd31 : flen[4:0] - 5'd1;
  assign sbit  = (flen != 6'd0) && ext[sidx];
  assign exts  = ext | (sbit ? ~lmask : '0);
  assign dmask = lmask << pos;
  assign dep   = (d32 & ~dmask) | ((ins << pos) & dmask);

  logic [DW-1:0] nres;
  logic          nflag, upd;

  always_comb begin
    nres  = result;
    nflag = tflag;
    upd   = 1'b1;
    case (op)
      4'd0: nres = neg ? asr : shl;
      4'd1: nres = neg ? lsr : shl;
      4'd2: nres = rot;
      4'd3: nres = {8'd0, d32 | bit1};
      4'd4: nres = {8'd0, d32 & ~bit1};
      4'd5: nres = {8'd0, d32 ^ bit1};
      4'd6: nflag = d32[pos];
      4'd7: nres = {8'd0, ext};
      4'd8: nres = {8'd0, exts};
      4'd9: nres = {8'd0, dep};
      default: upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      tflag  <= 1'b0;
    end else if (in_valid && upd) begin
      result <= nres;
      tflag  <= nflag;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(tflag)));

  assert_w16_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op <= 4'd2 && wsel == 2'd0) |=> (result[39:16] == 24'd0));

  assert_bitop_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd3 && op <= 4'd5) |=> (result[39:32] == 8'd0));

  assert_test_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd6) |=> $stable(result));

  assert_flag_only_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 4'd6) |=> $stable(tflag));

  assert_undef_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd10) |=> ($stable(result) && $stable(tflag)));
endmodule

// File: tb/bshift_bitfield_tb.sv
module bshift_bitfield_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  wsel = '0;
  logic [39:0] src = '0;
  logic [6:0]  amt = '0;
  logic [5:0]  flen = '0;
  logic [31:0] ins = '0;
  logic [39:0] result;
  logic        tflag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bshift_bitfield dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .wsel(wsel), .src(src), .amt(amt), .flen(flen), .ins(ins),
    .result(result), .tflag(tflag));

  task automatic chk(input string req, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [1:0] w, input logic [39:0] s,
                     input logic [6:0] a, input logic [5:0] l, input logic [31:0] d);
    @(negedge clk);
    op = o; wsel = w; src = s; amt = a; flen = l; ins = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 result", result, 40'd0);
    chk("R1 flag", {39'd0, tflag}, 40'd0);
  endtask

  task automatic t_arith();
    run(4'd0, 2'd0, 40'hFF_FFFF_8001, -7'sd1, 6'd0, 0); chk("R4/R3 w16 asr", result, 40'h00_0000_C000);
    run(4'd0, 2'd0, 40'h00_0000_8001, 7'd4, 6'd0, 0);   chk("R4 w16 asl", result, 40'h00_0000_0010);
    run(4'd0, 2'd2, 40'h80_0000_0000, -7'sd4, 6'd0, 0); chk("R4 w40 asr", result, 40'hF8_0000_0000);
    run(4'd0, 2'd2, 40'h80_0000_0000, -7'sd50, 6'd0, 0); chk("R4 w40 asr over", result, 40'hFF_FFFF_FFFF);
    run(4'd0, 2'd1, 40'h00_4000_0000, -7'sd4, 6'd0, 0); chk("R4 w32 asr pos", result, 40'h00_0400_0000);
  endtask

  task automatic t_logic();
    run(4'd1, 2'd1, 40'h00_8000_0000, -7'sd31, 6'd0, 0); chk("R5 lsr 31", result, 40'h00_0000_0001);
    run(4'd1, 2'd1, 40'hAA_8000_0000, -7'sd4, 6'd0, 0);  chk("R5/R3 lsr 4", result, 40'h00_0800_0000);
    run(4'd1, 2'd1, 40'h00_0000_0001, 7'd40, 6'd0, 0);   chk("R5 lsl over", result, 40'd0);
    run(4'd1, 2'd2, 40'hFF_0000_0000, -7'sd8, 6'd0, 0);  chk("R5 w40 lsr", result, 40'h00_FF00_0000);
  endtask

  task automatic t_rot();
    run(4'd2, 2'd0, 40'h00_0000_8001, 7'd1, 6'd0, 0);    chk("R6 w16 rol", result, 40'h00_0000_0003);
    run(4'd2, 2'd0, 40'h00_0000_8001, -7'sd1, 6'd0, 0);  chk("R6 w16 ror", result, 40'h00_0000_C000);
    run(4'd2, 2'd0, 40'h00_0000_8001, 7'd17, 6'd0, 0);   chk("R6 w16 mod", result, 40'h00_0000_0003);
    run(4'd2, 2'd2, 40'h80_0000_0001, 7'd4, 6'd0, 0);    chk("R6 w40 rol", result, 40'h00_0000_0018);
    run(4'd2, 2'd3, 40'h80_0000_0001, 7'd44, 6'd0, 0);   chk("R6 w40 mod", result, 40'h00_0000_0018);
    run(4'd2, 2'd1, 40'h00_1234_5678, 7'd8, 6'd0, 0);    chk("R6 w32 rol", result, 40'h00_3456_7812);
    run(4'd2, 2'd1, 40'h00_1234_5678, -7'sd8, 6'd0, 0);  chk("R6 w32 ror", result, 40'h00_7812_3456);
  endtask

  task automatic t_bits();
    run(4'd3, 2'd0, 40'h00_0000_0000, 7'd31, 6'd0, 0);   chk("R7 set 31", result, 40'h00_8000_0000);
    run(4'd3, 2'd0, 40'hAB_0000_0000, 7'd0, 6'd0, 0);    chk("R7 set upper0", result, 40'h00_0000_0001);
    run(4'd3, 2'd0, 40'h00_0000_0000, 7'd37, 6'd0, 0);   chk("R7 pos low5", result, 40'h00_0000_0020);
    run(4'd4, 2'd0, 40'h00_FFFF_FFFF, 7'd4, 6'd0, 0);    chk("R7 clr", result, 40'h00_FFFF_FFEF);
    run(4'd5, 2'd0, 40'h00_0000_00F0, 7'd4, 6'd0, 0);    chk("R7 tgl off", result, 40'h00_0000_00E0);
    run(4'd5, 2'd0, 40'h00_0000_00F0, 7'd8, 6'd0, 0);    chk("R7 tgl on", result, 40'h00_0000_01F0);
  endtask

  task automatic t_test();
    run(4'd6, 2'd0, 40'h00_0000_0004, 7'd2, 6'd0, 0);
    chk("R8 flag set", {39'd0, tflag}, 40'd1);
    chk("R8 result kept", result, 40'h00_0000_01F0);
    run(4'd1, 2'd1, 40'h00_0000_0010, -7'sd1, 6'd0, 0);
    chk("R8 flag kept by shift", {39'd0, tflag}, 40'd1);
    chk("R5 lsr 1", result, 40'h00_0000_0008);
    run(4'd6, 2'd0, 40'h00_0000_0004, 7'd3, 6'd0, 0);
    chk("R8 flag clear", {39'd0, tflag}, 40'd0);
  endtask

  task automatic t_extract();
    run(4'd7, 2'd0, 40'h00_DEAD_BEEF, 7'd8, 6'd8, 0);   chk("R9 mid", result, 40'h00_0000_00BE);
    run(4'd7, 2'd0, 40'h00_DEAD_BEEF, 7'd28, 6'd8, 0);  chk("R9 past 31", result, 40'h00_0000_000D);
    run(4'd7, 2'd0, 40'h00_DEAD_BEEF, 7'd0, 6'd32, 0);  chk("R9 full", result, 40'h00_DEAD_BEEF);
    run(4'd7, 2'd0, 40'h00_DEAD_BEEF, 7'd4, 6'd0, 0);   chk("R9 len0", result, 40'd0);
    run(4'd8, 2'd0, 40'h00_DEAD_BEEF, 7'd8, 6'd8, 0);   chk("R10 neg", result, 40'h00_FFFF_FFBE);
    run(4'd8, 2'd0, 40'h00_DEAD_BEEF, 7'd16, 6'd4, 0);  chk("R10 nibble", result, 40'h00_FFFF_FFFD);
    run(4'd8, 2'd0, 40'h00_0000_007F, 7'd0, 6'd8, 0);   chk("R10 pos", result, 40'h00_0000_007F);
    run(4'd8, 2'd0, 40'h00_FFFF_FFFF, 7'd0, 6'd0, 0);   chk("R10 len0", result, 40'd0);
  endtask

  task automatic t_deposit();
    run(4'd9, 2'd0, 40'h00_FFFF_FFFF, 7'd8, 6'd4, 32'h0);          chk("R11 clear nib", result, 40'h00_FFFF_F0FF);
    run(4'd9, 2'd0, 40'h00_0000_0000, 7'd28, 6'd8, 32'hFFFF_FFFF); chk("R11 trunc", result, 40'h00_F000_0000);
    run(4'd9, 2'd0, 40'h00_1234_5678, 7'd4, 6'd8, 32'h0000_03AB);  chk("R11 mid", result, 40'h00_1234_5AB8);
    run(4'd9, 2'd0, 40'hFF_1234_5678, 7'd0, 6'd32, 32'hCAFE_F00D); chk("R11 full", result, 40'h00_CAFE_F00D);
  endtask

  task automatic t_hold();
    run(4'd6, 2'd0, 40'h00_0000_0001, 7'd0, 6'd0, 0);
    run(4'd12, 2'd1, 40'h00_0000_0001, 7'd1, 6'd1, 32'h1);
    chk("R12 result", result, 40'h00_CAFE_F00D);
    chk("R12 flag", {39'd0, tflag}, 40'd1);
    run(4'd15, 2'd0, 40'h00_0000_0000, 7'd0, 6'd0, 0);
    chk("R12 flag f", {39'd0, tflag}, 40'd1);
    @(negedge clk);
    op = 4'd0; wsel = 2'd0; src = 40'h12_3456_789A; amt = 7'd3;
    @(negedge clk); @(negedge clk);
    chk("R2 no strobe", result, 40'h00_CAFE_F00D);
    op = 4'd6; amt = 7'd1;
    @(negedge clk);
    chk("R2 flag no strobe", {39'd0, tflag}, 40'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_arith();
    t_logic();
    t_rot();
    t_bits();
    t_test();
    t_extract();
    t_deposit();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule